// File: doc/BRIEF.md
# Register-Stage Arithmetic and Logic Executor for an 8-bit Instruction Set

This block executes the arithmetic and logic class of an 8-bit instruction set whose instructions are four bytes long: an opcode byte, two source bytes and a destination byte. The opcode byte, the two source bytes and the two values already read from the register file arrive together with an input valid bit. The two top opcode bits pick each source operand independently: the raw instruction byte (immediate) or the register value. The low nibble selects one of eleven operations.

After one clock edge the block presents the 8-bit result, a write enable for the destination register, the destination number (the fourth instruction byte, passed through unchanged), and two flags. One flag marks a reserved code inside the arithmetic/logic class. The other marks an opcode that belongs to a different class, such as memory, branch or stack, and that must be handled elsewhere.

The stage has no multi-state controller. Its only state is the output register: after reset it is **CLEAR**, and every edge **LOAD**s it from the current inputs. An idle input loads a quiet, all-zero output word.

Top module: `alu8_exec_stage`

## Requirements
- R1: Opcode bit 7 set makes operand A the byte `fld_a`, clear makes it `rd_a`; opcode bit 6 likewise picks `fld_b` or `rd_b` for operand B.
- R2: With opcode bits 5:4 = 00, code 0 gives A+B and code 1 gives A−B, both modulo 256.
- R3: Code 2 gives A AND B, code 3 gives A OR B, code 5 gives A XOR B, and code 4 gives NOT A, on which operand B has no effect.
- R4: Code 6 shifts A left by B and code 7 shifts A right logically by B, filling with zeros; any amount B ≥ 8 yields 0.
- R5: Code 8 rotates A left and code 9 rotates A right, by B modulo 8.
- R6: Code 10 yields the low 8 bits of A×B.
- R7: With bits 5:4 = 00, codes 11 to 15 raise `out_illegal`, keep `out_we` low and give a result of 0.
- R8: Any opcode with bits 5:4 ≠ 00 raises `out_not_alu`, keeps `out_we` and `out_illegal` low and gives a result of 0.
- R9: `out_dst` equals the `fld_dst` byte presented with the instruction, and `out_we` is high exactly for a valid instruction with codes 0 to 10.
- R10: All outputs appear one clock after their inputs, `out_valid` follows `in_valid` one clock later, and while `rst_n` is low every output is 0.
- R11: When `in_valid` is low, the next output word is all zero: no write, no flags, a result of 0 and a destination of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opc | input | 8 | Opcode byte |
| fld_a | input | 8 | Second instruction byte, immediate for operand A |
| fld_b | input | 8 | Third instruction byte, immediate for operand B |
| fld_dst | input | 8 | Fourth instruction byte, destination register number |
| rd_a | input | 8 | Register value for operand A |
| rd_b | input | 8 | Register value for operand B |
| out_valid | output | 1 | Output word is valid |
| out_res | output | 8 | Operation result |
| out_we | output | 1 | Destination register write enable |
| out_dst | output | 8 | Destination register number |
| out_illegal | output | 1 | Reserved code inside the arithmetic/logic class |
| out_not_alu | output | 1 | Opcode belongs to another instruction class |

## Verification
The bench builds the stage with its default word width of 8. At that width, every 8-bit shift amount can be driven, so both the saturating boundary at 8 and the largest amounts of 255 are tested, together with rotates whose amounts wrap past 8. Multiply and subtract vectors are chosen so that the product overflows and the difference goes below zero. All five reserved codes and every foreign class bit pattern are also driven.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_NOT = 4'd4,
        OP_XOR = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9,
        OP_MUL = 4'd10
    } alu_op_e;

    localparam logic [3:0] LAST_CODE = 4'd10;

    typedef struct packed {
        logic       legal;
        logic       illegal;
        logic       not_alu;
        logic [3:0] code;
    } alu_dec_t;

endpackage

// File: rtl/alu8_decode.sv
`timescale 1ns/1ps
module alu8_decode
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [7:0]   opc,
    input  logic [W-1:0] imm_a,
    input  logic [W-1:0] imm_b,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    output logic [W-1:0] src_a,
    output logic [W-1:0] src_b,
    output alu_dec_t     dec
);

    logic foreign;
    logic reserved;

    always_comb begin
        src_a = opc[7] ? imm_a : reg_a;
        src_b = opc[6] ? imm_b : reg_b;
    end

    always_comb begin
        foreign     = (opc[5:4] != 2'b00);
        reserved    = !foreign && (opc[3:0] > LAST_CODE);
        dec.code    = opc[3:0];
        dec.not_alu = foreign;
        dec.illegal = reserved;
        dec.legal   = !foreign && !reserved;
    end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int SW = $clog2(W);
    localparam logic [W-1:0] LIM  = W'(W);
    localparam logic [SW:0]  WV   = (SW+1)'(W);

    logic [SW-1:0] rot;
    logic [SW:0]   rot_back;
    logic          sat;

    always_comb begin
        rot      = b[SW-1:0];
        rot_back = WV - {1'b0, rot};
        sat      = (b >= LIM);
    end

    always_comb begin
        unique case (code)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOT:  y = ~a;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = sat ? '0 : (a << b);
            OP_SHR:  y = sat ? '0 : (a >> b);
            OP_ROL:  y = (a << rot) | (a >> rot_back);
            OP_ROR:  y = (a >> rot) | (a << rot_back);
            OP_MUL:  y = a * b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu8_exec_stage.sv
`timescale 1ns/1ps
module alu8_exec_stage
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   opc,
    input  logic [W-1:0] fld_a,
    input  logic [W-1:0] fld_b,
    input  logic [7:0]   fld_dst,
    input  logic [W-1:0] rd_a,
    input  logic [W-1:0] rd_b,
    output logic         out_valid,
    output logic [W-1:0] out_res,
    output logic         out_we,
    output logic [7:0]   out_dst,
    output logic         out_illegal,
    output logic         out_not_alu
);

    logic [W-1:0] src_a;
    logic [W-1:0] src_b;
    logic [W-1:0] core_y;
    alu_dec_t     dec;
    logic         do_write;

    alu8_decode #(.W(W)) i_decode (
        .opc   (opc),
        .imm_a (fld_a),
        .imm_b (fld_b),
        .reg_a (rd_a),
        .reg_b (rd_b),
        .src_a (src_a),
        .src_b (src_b),
        .dec   (dec)
    );

    alu8_core #(.W(W)) i_core (
        .code (dec.code),
        .a    (src_a),
        .b    (src_b),
        .y    (core_y)
    );

    always_comb begin
        do_write = in_valid && dec.legal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_res     <= '0;
            out_we      <= 1'b0;
            out_dst     <= '0;
            out_illegal <= 1'b0;
            out_not_alu <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_res     <= do_write ? core_y : '0;
            out_we      <= do_write;
            out_dst     <= in_valid ? fld_dst : '0;
            out_illegal <= in_valid && dec.illegal;
            out_not_alu <= in_valid && dec.not_alu;
        end
    end

    // R7
    ill_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_we && out_res == '0 && !out_not_alu));

    // R8
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_not_alu |-> (!out_we && !out_illegal && out_res == '0));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_we && !out_illegal && !out_not_alu));

    // R9
    dst_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dst == $past(fld_dst)));

    // R4
    shl_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc[5:0] == 6'h06 && (opc[6] ? fld_b : rd_b) >= W'(W))
        |=> (out_res == '0 && out_we));

endmodule

// File: tb/test_alu8_exec_stage.sv
`timescale 1ns/1ps
module test_alu8_exec_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] opc = '0, fld_a = '0, fld_b = '0, fld_dst = '0, rd_a = '0, rd_b = '0;
    logic       out_valid, out_we, out_illegal, out_not_alu;
    logic [7:0] out_res, out_dst;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    alu8_exec_stage #(.W(8)) i_alu8_exec_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opc(opc),
        .fld_a(fld_a), .fld_b(fld_b), .fld_dst(fld_dst), .rd_a(rd_a), .rd_b(rd_b),
        .out_valid(out_valid), .out_res(out_res), .out_we(out_we), .out_dst(out_dst),
        .out_illegal(out_illegal), .out_not_alu(out_not_alu)
    );

    // Behavioural reference: returns {valid, res, we, dst, ill, nal}
    function automatic logic [19:0] model(input logic v, input logic [7:0] o,
        input logic [7:0] fa, input logic [7:0] fb, input logic [7:0] fd,
        input logic [7:0] ra, input logic [7:0] rb);
        int a, b, r, code;
        logic we, ill, nal;
        a = o[7] ? int'(fa) : int'(ra);
        b = o[6] ? int'(fb) : int'(rb);
        code = int'(o[3:0]);
        nal = v && (o[5:4] != 0);
        ill = v && !nal && code > 10;
        we  = v && !nal && !ill;
        r = 0;
        case (code)
            0: r = (a + b) % 256;
            1: r = (a - b + 256) % 256;
            2: r = a & b;
            3: r = a | b;
            4: r = 255 - a;
            5: r = a ^ b;
            6: r = (b >= 8) ? 0 : ((a << b) % 256);
            7: r = (b >= 8) ? 0 : (a >> b);
            8: r = ((a << (b % 8)) | (a >> (8 - b % 8))) % 256;
            9: r = ((a >> (b % 8)) | (a << (8 - b % 8))) % 256;
            10: r = (a * b) % 256;
            default: r = 0;
        endcase
        if (!we) r = 0;
        return {v, 8'(r), we, (v ? fd : 8'd0), ill, nal};
    endfunction

    function automatic logic [19:0] observed();
        return {out_valid, out_res, out_we, out_dst, out_illegal, out_not_alu};
    endfunction

    task automatic compare(input string tag, input logic [19:0] exp);
        checks++;
        if (observed() !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h (valid,res,we,dst,ill,nal)",
                     tag, observed(), exp);
        end
    endtask

    // drive at negedge, output registered at next posedge, sample at following negedge
    task automatic apply(input string tag, input logic v, input logic [7:0] o,
        input logic [7:0] fa, input logic [7:0] fb, input logic [7:0] fd,
        input logic [7:0] ra, input logic [7:0] rb);
        logic [19:0] exp;
        in_valid = v; opc = o; fld_a = fa; fld_b = fb; fld_dst = fd; rd_a = ra; rd_b = rb;
        exp = model(v, o, fa, fb, fd, ra, rb);
        @(negedge clk);
        compare(tag, exp);
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        compare("R10 reset", 20'h0);
        rst_n = 1'b1;
        // R1: operand source selection, add with all four combinations
        apply("R1 reg/reg", 1'b1, 8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20);
        apply("R1 imm/reg", 1'b1, 8'h80, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20);
        apply("R1 reg/imm", 1'b1, 8'h40, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20);
        apply("R1 imm/imm", 1'b1, 8'hC0, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20);
        // R2
        apply("R2 add wrap", 1'b1, 8'hC0, 8'hF0, 8'h20, 8'h01, 8'h0, 8'h0);
        apply("R2 sub borrow", 1'b1, 8'hC1, 8'h03, 8'h05, 8'h02, 8'h0, 8'h0);
        // R3
        apply("R3 and", 1'b1, 8'h02, 8'h0, 8'h0, 8'h04, 8'hCC, 8'hAA);
        apply("R3 or",  1'b1, 8'h03, 8'h0, 8'h0, 8'h04, 8'hCC, 8'hAA);
        apply("R3 xor", 1'b1, 8'h05, 8'h0, 8'h0, 8'h04, 8'hCC, 8'hAA);
        apply("R3 not b0", 1'b1, 8'h04, 8'h0, 8'h0, 8'h04, 8'h3C, 8'h00);
        apply("R3 not b ignored", 1'b1, 8'h44, 8'h0, 8'hFF, 8'h04, 8'h3C, 8'h00);
        // R4
        apply("R4 shl 3", 1'b1, 8'h46, 8'h0, 8'd3, 8'h05, 8'h81, 8'h0);
        apply("R4 shl 7", 1'b1, 8'h46, 8'h0, 8'd7, 8'h05, 8'h81, 8'h0);
        apply("R4 shl 8", 1'b1, 8'h46, 8'h0, 8'd8, 8'h05, 8'hFF, 8'h0);
        apply("R4 shl 255", 1'b1, 8'h46, 8'h0, 8'd255, 8'h05, 8'hFF, 8'h0);
        apply("R4 shr 1", 1'b1, 8'h47, 8'h0, 8'd1, 8'h05, 8'h81, 8'h0);
        apply("R4 shr 7", 1'b1, 8'h47, 8'h0, 8'd7, 8'h05, 8'h81, 8'h0);
        apply("R4 shr 9", 1'b1, 8'h47, 8'h0, 8'd9, 8'h05, 8'hFF, 8'h0);
        // R5
        apply("R5 rol 1", 1'b1, 8'h48, 8'h0, 8'd1, 8'h06, 8'h81, 8'h0);
        apply("R5 rol 9", 1'b1, 8'h48, 8'h0, 8'd9, 8'h06, 8'h81, 8'h0);
        apply("R5 rol 0", 1'b1, 8'h48, 8'h0, 8'd0, 8'h06, 8'h5A, 8'h0);
        apply("R5 ror 3", 1'b1, 8'h49, 8'h0, 8'd3, 8'h06, 8'h0F, 8'h0);
        apply("R5 ror 8", 1'b1, 8'h49, 8'h0, 8'd8, 8'h06, 8'h0F, 8'h0);
        // R6
        apply("R6 mul 16x17", 1'b1, 8'hCA, 8'd16, 8'd17, 8'h07, 8'h0, 8'h0);
        apply("R6 mul ffxff", 1'b1, 8'h0A, 8'h0, 8'h0, 8'h07, 8'hFF, 8'hFF);
        // R7
        for (int c = 11; c < 16; c++)
            apply("R7 reserved", 1'b1, 8'(c), 8'h0, 8'h0, 8'h08, 8'h12, 8'h34);
        // R8
        apply("R8 class 01", 1'b1, 8'h10, 8'h0, 8'h0, 8'h09, 8'h12, 8'h34);
        apply("R8 class 10", 1'b1, 8'hA6, 8'h0, 8'h0, 8'h09, 8'h12, 8'h34);
        apply("R8 class 11", 1'b1, 8'h35, 8'h0, 8'h0, 8'h09, 8'h12, 8'h34);
        // R9
        apply("R9 dst pass", 1'b1, 8'h00, 8'h0, 8'h0, 8'hE7, 8'h01, 8'h01);
        // R11
        apply("R11 idle", 1'b0, 8'h00, 8'h0, 8'h0, 8'hE7, 8'h01, 8'h01);
        apply("R10 resume", 1'b1, 8'h01, 8'h0, 8'h0, 8'h02, 8'h09, 8'h04);
        // mixed sweep
        lf = 8'h5B;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            apply("R2 sweep", lf[0] | lf[3], {lf[7:6], (i % 5 == 0) ? lf[5:4] : 2'b00, 4'(i % 16)},
                  lf ^ 8'h3C, 8'(i), 8'(i * 7), lf, ~lf);
        end
        rst_n = 1'b0;
        @(negedge clk);
        compare("R10 reset again", 20'h0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule